// File: doc/BRIEF.md
# Ring Interrupt Packet Receiver

This block sits at one node of a ring network. Small interrupt packets travel the ring alongside ordinary data traffic. Each packet carries the ID of the node that sent it, a target ID, an interrupt type and a 32-bit payload. A packet is either addressed to one node or broadcast to every node.

The block checks each interrupt packet that passes the node. A packet is accepted when it is addressed to this node, or when it is a broadcast that another node sent. The sender ID and the payload of an accepted packet go into a FIFO pair chosen by the packet's type. There are four types, and each has a 127-entry sender FIFO and a 127-entry payload FIFO that move in step. A status bit for each type stays high while that type's FIFO holds entries. The status bits are masked by per-type enables and a global enable, and the result drives one host interrupt line.

The same register port lets the local host send an interrupt packet. It loads a target and a payload, then writes the type, and that write emits the packet. Passing packets on around the ring is done outside this block.

Top module: `ring_irq_top`

## Requirements
- R1: A valid packet whose target equals `node_id` is pushed into the FIFO selected by `rx_type` (value 0 to 3). Its sender ID and payload then appear together at `head_src`/`head_data` slice `rx_type` (bits t*8 and t*32 upward).
- R2: A valid packet whose target is all ones (8'hFF) is accepted as a broadcast. The exception is a broadcast whose sender equals `node_id`: that packet is discarded.
- R3: A valid packet whose target is neither `node_id` nor 8'hFF changes no FIFO, status bit or overflow flag.
- R4: Each type's FIFO returns entries in arrival order. A one-cycle `pop_req[t]` removes the head sender ID and payload together. A pop on an empty FIFO has no effect.
- R5: `irq_status[t]` is high exactly when FIFO t holds at least one entry. It rises at the same clock edge that stores the first entry, and it falls at the edge that removes the last one.
- R6: Each FIFO holds 127 entries. A packet that matches a full FIFO is dropped, and `irq_ovf[t]` is set. The flag stays set until a write to register 4 with bit t of the data at one. Any other bit at zero leaves its flag unchanged.
- R7: `host_irq` is high exactly when the global enable and at least one pair of `irq_status[t]` and its local enable bit are high. Register 3 holds the local enables in data bits 3:0 and the global enable in bit 8.
- R8: A write to register 0 sets the target from data bits 7:0. A write to register 1 sets the payload. A write to register 2 takes the type from data bits 1:0 and emits one packet: `tx_valid` is high for the single following cycle, with `tx_src` = `node_id` and the stored target and payload.
- R9: After reset all FIFOs are empty, and `irq_status`, `irq_ovf`, `host_irq`, `tx_valid` and all enables are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| node_id | input | 8 | This node's ID |
| rx_valid | input | 1 | Incoming packet valid for one cycle |
| rx_src | input | 8 | Sender ID of incoming packet |
| rx_dst | input | 8 | Target ID, 8'hFF for broadcast |
| rx_type | input | 2 | Interrupt type |
| rx_data | input | 32 | Packet payload |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | 0 target, 1 payload, 2 type+send, 3 enables, 4 overflow clear |
| reg_wdata | input | 32 | Register write data |
| tx_valid | output | 1 | Outgoing packet valid |
| tx_src | output | 8 | Outgoing sender ID |
| tx_dst | output | 8 | Outgoing target ID |
| tx_type | output | 2 | Outgoing type |
| tx_data | output | 32 | Outgoing payload |
| pop_req | input | 4 | Per-type pop strobe |
| head_src | output | 32 | Head sender IDs, 8 bits per type |
| head_data | output | 128 | Head payloads, 32 bits per type |
| irq_status | output | 4 | Per-type FIFO non-empty |
| irq_ovf | output | 4 | Per-type sticky overflow |
| host_irq | output | 1 | Masked host interrupt |

## Verification
The hardest case to reach is the overflow boundary. The bench fills one type's FIFO with exactly 127 directed packets and offers a 128th. It then checks that the flag rises and that draining returns only the first 127 entries in order. It also clears the flag with a write that has that bit set and the other bits at zero, and checks that the other flags are unchanged. A self-sent broadcast is interleaved with foreign broadcasts and with packets for other nodes, so any wrongly accepted packet shows up as an extra scoreboard entry.

// File: rtl/ring_irq_pkg.sv
// Shared definitions for the ring interrupt receiver.
package ring_irq_pkg;
    // Register addresses on the local write port.
    typedef enum logic [2:0] {
        REG_TARGET  = 3'd0,
        REG_PAYLOAD = 3'd1,
        REG_SEND    = 3'd2,
        REG_ENABLE  = 3'd3,
        REG_OVF_CLR = 3'd4
    } reg_sel_e;

    // Bit position of the global enable inside the enable register.
    localparam int GLOBAL_EN_BIT = 8;
endpackage

// File: rtl/ring_irq_filter.sv
// Packet acceptance filter.
// Decides whether an incoming packet belongs to this node and, if it does,
// raises one push strobe for its type. Assumes at most one packet per cycle
// and that the broadcast target is the all-ones ID.
module ring_irq_filter #(
    parameter int ID_W    = 8,
    parameter int DATA_W  = 32,
    parameter int N_TYPES = 4,
    localparam int TYPE_W = $clog2(N_TYPES)
) (
    input  logic                   rx_valid,
    input  logic [ID_W-1:0]        rx_src,
    input  logic [ID_W-1:0]        rx_dst,
    input  logic [TYPE_W-1:0]      rx_type,
    input  logic [DATA_W-1:0]      rx_data,
    input  logic [ID_W-1:0]        node_id,
    output logic [N_TYPES-1:0]     push_req,
    output logic [ID_W+DATA_W-1:0] push_word
);
    localparam logic [ID_W-1:0] BCAST_ID = '1;

    logic directed_hit;
    logic bcast_hit;

    // Classify the packet as directed, foreign broadcast or neither.
    always_comb begin
        directed_hit = rx_valid && (rx_dst == node_id);
        bcast_hit    = rx_valid && (rx_dst == BCAST_ID) && (rx_src != node_id);
    end

    // Steer an accepted packet to its type's FIFO.
    always_comb begin
        push_req = '0;
        if (directed_hit || bcast_hit) begin
            push_req[rx_type] = 1'b1;
        end
        push_word = {rx_src, rx_data};
    end
endmodule

// File: rtl/ring_irq_fifo.sv
// Paired sender/payload FIFO for one interrupt type.
// Sender ID and payload share one storage word, so both halves are always
// written and removed together. The head is shown without a read delay.
// A push into a full FIFO is dropped and reported on drop. DEPTH need not be
// a power of two.
module ring_irq_fifo #(
    parameter int WIDTH = 40,
    parameter int DEPTH = 127,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full,
    output logic             drop
);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push;
    logic             do_pop;

    // Qualify requests against the current fill level.
    always_comb begin
        empty   = (count == '0);
        full    = (count == FULL_CNT);
        do_push = push && !full;
        do_pop  = pop && !empty;
        drop    = push && full;
        rdata   = mem[rd_ptr];
    end

    // Store accepted words.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    // Advance pointers with explicit wrap and track the fill count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/ring_irq_ctrl.sv
// Local register port, packet emitter, overflow flags and interrupt mask.
// Takes the target and payload from earlier writes. A write of the type
// register emits one packet in the next cycle. Overflow flags are sticky and
// cleared by write-one-to-clear; a new drop in the same cycle wins.
module ring_irq_ctrl
    import ring_irq_pkg::*;
#(
    parameter int ID_W    = 8,
    parameter int DATA_W  = 32,
    parameter int N_TYPES = 4,
    localparam int TYPE_W = $clog2(N_TYPES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ID_W-1:0]    node_id,
    input  logic               reg_we,
    input  logic [2:0]         reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    input  logic [N_TYPES-1:0] drop,
    input  logic [N_TYPES-1:0] status,
    output logic               tx_valid,
    output logic [ID_W-1:0]    tx_src,
    output logic [ID_W-1:0]    tx_dst,
    output logic [TYPE_W-1:0]  tx_type,
    output logic [DATA_W-1:0]  tx_data,
    output logic [N_TYPES-1:0] en_local,
    output logic               en_global,
    output logic [N_TYPES-1:0] ovf,
    output logic               host_irq
);
    logic [ID_W-1:0]   target_q;
    logic [DATA_W-1:0] payload_q;
    logic [TYPE_W-1:0] type_q;
    logic              send_q;
    logic              wr_target;
    logic              wr_payload;
    logic              wr_send;
    logic              wr_enable;
    logic              wr_ovf_clr;

    // Decode the write address.
    always_comb begin
        wr_target  = reg_we && (reg_addr == REG_TARGET);
        wr_payload = reg_we && (reg_addr == REG_PAYLOAD);
        wr_send    = reg_we && (reg_addr == REG_SEND);
        wr_enable  = reg_we && (reg_addr == REG_ENABLE);
        wr_ovf_clr = reg_we && (reg_addr == REG_OVF_CLR);
    end

    // Hold the outgoing packet fields and the one-cycle send pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target_q  <= '0;
            payload_q <= '0;
            type_q    <= '0;
            send_q    <= 1'b0;
        end else begin
            if (wr_target)  target_q  <= reg_wdata[ID_W-1:0];
            if (wr_payload) payload_q <= reg_wdata;
            if (wr_send)    type_q    <= reg_wdata[TYPE_W-1:0];
            send_q <= wr_send;
        end
    end

    // Interrupt enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_local  <= '0;
            en_global <= 1'b0;
        end else if (wr_enable) begin
            en_local  <= reg_wdata[N_TYPES-1:0];
            en_global <= reg_wdata[GLOBAL_EN_BIT];
        end
    end

    // Sticky overflow flags with write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf <= '0;
        end else begin
            ovf <= (ovf & ~(wr_ovf_clr ? reg_wdata[N_TYPES-1:0] : '0)) | drop;
        end
    end

    // Drive the emitter outputs and the masked interrupt.
    always_comb begin
        tx_valid = send_q;
        tx_src   = node_id;
        tx_dst   = target_q;
        tx_type  = type_q;
        tx_data  = payload_q;
        host_irq = en_global && |(status & en_local);
    end
endmodule

// File: rtl/ring_irq_top.sv
// Ring interrupt packet receiver, top level.
// Joins the acceptance filter, one paired FIFO per type and the control
// block. Assumes synchronous active-low reset and one packet per cycle.
module ring_irq_top #(
    parameter int ID_W    = 8,
    parameter int DATA_W  = 32,
    parameter int N_TYPES = 4,
    parameter int DEPTH   = 127,
    localparam int TYPE_W = $clog2(N_TYPES),
    localparam int WORD_W = ID_W + DATA_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ID_W-1:0]           node_id,
    input  logic                      rx_valid,
    input  logic [ID_W-1:0]           rx_src,
    input  logic [ID_W-1:0]           rx_dst,
    input  logic [TYPE_W-1:0]         rx_type,
    input  logic [DATA_W-1:0]         rx_data,
    input  logic                      reg_we,
    input  logic [2:0]                reg_addr,
    input  logic [DATA_W-1:0]         reg_wdata,
    output logic                      tx_valid,
    output logic [ID_W-1:0]           tx_src,
    output logic [ID_W-1:0]           tx_dst,
    output logic [TYPE_W-1:0]         tx_type,
    output logic [DATA_W-1:0]         tx_data,
    input  logic [N_TYPES-1:0]        pop_req,
    output logic [N_TYPES*ID_W-1:0]   head_src,
    output logic [N_TYPES*DATA_W-1:0] head_data,
    output logic [N_TYPES-1:0]        irq_status,
    output logic [N_TYPES-1:0]        irq_ovf,
    output logic                      host_irq
);
    logic [N_TYPES-1:0] push_req;
    logic [WORD_W-1:0]  push_word;
    logic [N_TYPES-1:0] fifo_empty;
    logic [N_TYPES-1:0] fifo_full;
    logic [N_TYPES-1:0] fifo_drop;
    logic [N_TYPES-1:0] en_local;
    logic               en_global;

    ring_irq_filter #(
        .ID_W(ID_W), .DATA_W(DATA_W), .N_TYPES(N_TYPES)
    ) filter_i (
        .rx_valid (rx_valid),
        .rx_src   (rx_src),
        .rx_dst   (rx_dst),
        .rx_type  (rx_type),
        .rx_data  (rx_data),
        .node_id  (node_id),
        .push_req (push_req),
        .push_word(push_word)
    );

    for (genvar t = 0; t < N_TYPES; t++) begin : g_type
        logic [WORD_W-1:0] head_word;

        ring_irq_fifo #(
            .WIDTH(WORD_W), .DEPTH(DEPTH)
        ) fifo_i (
            .clk  (clk),
            .rst_n(rst_n),
            .push (push_req[t]),
            .wdata(push_word),
            .pop  (pop_req[t]),
            .rdata(head_word),
            .empty(fifo_empty[t]),
            .full (fifo_full[t]),
            .drop (fifo_drop[t])
        );

        // Split the head word onto the per-type output slices.
        always_comb begin
            head_src[t*ID_W +: ID_W]       = head_word[WORD_W-1:DATA_W];
            head_data[t*DATA_W +: DATA_W]  = head_word[DATA_W-1:0];
            irq_status[t]                  = !fifo_empty[t];
        end
    end

    ring_irq_ctrl #(
        .ID_W(ID_W), .DATA_W(DATA_W), .N_TYPES(N_TYPES)
    ) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .node_id  (node_id),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .drop     (fifo_drop),
        .status   (irq_status),
        .tx_valid (tx_valid),
        .tx_src   (tx_src),
        .tx_dst   (tx_dst),
        .tx_type  (tx_type),
        .tx_data  (tx_data),
        .en_local (en_local),
        .en_global(en_global),
        .ovf      (irq_ovf),
        .host_irq (host_irq)
    );
endmodule

// File: rtl/ring_irq_checker.sv
// Temporal checks for ring_irq_top, attached with bind.
module ring_irq_checker
    import ring_irq_pkg::*;
#(
    parameter int ID_W    = 8,
    parameter int N_TYPES = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ID_W-1:0]    node_id,
    input logic               rx_valid,
    input logic [ID_W-1:0]    rx_src,
    input logic [ID_W-1:0]    rx_dst,
    input logic               reg_we,
    input logic [2:0]         reg_addr,
    input logic               tx_valid,
    input logic [N_TYPES-1:0] push_req,
    input logic [N_TYPES-1:0] fifo_full,
    input logic [N_TYPES-1:0] fifo_empty,
    input logic [N_TYPES-1:0] pop_req,
    input logic [N_TYPES-1:0] irq_status,
    input logic [N_TYPES-1:0] irq_ovf,
    input logic [N_TYPES-1:0] en_local,
    input logic               en_global,
    input logic               host_irq
);
    localparam logic [ID_W-1:0] BCAST_ID = '1;

    assert_single_push_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(push_req));

    assert_own_bcast_dropped_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && (rx_dst == BCAST_ID) && (rx_src == node_id) |-> push_req == '0);

    assert_foreign_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && (rx_dst != BCAST_ID) && (rx_dst != node_id) |-> push_req == '0);

    assert_host_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> en_global && ((irq_status & en_local) != '0));

    assert_send_emits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we && (reg_addr == REG_SEND) |=> tx_valid);

    for (genvar t = 0; t < N_TYPES; t++) begin : g_chk
        assert_push_sets_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
            push_req[t] && !fifo_full[t] |=> irq_status[t]);

        assert_drop_sets_ovf_R6: assert property (@(posedge clk) disable iff (!rst_n)
            push_req[t] && fifo_full[t] |=> irq_ovf[t]);

        assert_empty_pop_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
            pop_req[t] && fifo_empty[t] && !push_req[t] |=> fifo_empty[t]);
    end
endmodule

bind ring_irq_top ring_irq_checker #(
    .ID_W(ID_W), .N_TYPES(N_TYPES)
) checker_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .node_id   (node_id),
    .rx_valid  (rx_valid),
    .rx_src    (rx_src),
    .rx_dst    (rx_dst),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .tx_valid  (tx_valid),
    .push_req  (push_req),
    .fifo_full (fifo_full),
    .fifo_empty(fifo_empty),
    .pop_req   (pop_req),
    .irq_status(irq_status),
    .irq_ovf   (irq_ovf),
    .en_local  (en_local),
    .en_global (en_global),
    .host_irq  (host_irq)
);

// File: tb/ring_irq_top_tb_top.sv
// Scoreboard bench for ring_irq_top.
module ring_irq_top_tb_top;
    localparam int NT = 4;
    localparam int DEPTH = 127;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  node_id = 8'h05;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_src = '0;
    logic [7:0]  rx_dst = '0;
    logic [1:0]  rx_type = '0;
    logic [31:0] rx_data = '0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        tx_valid;
    logic [7:0]  tx_src;
    logic [7:0]  tx_dst;
    logic [1:0]  tx_type;
    logic [31:0] tx_data;
    logic [NT-1:0]    pop_req = '0;
    logic [NT*8-1:0]  head_src;
    logic [NT*32-1:0] head_data;
    logic [NT-1:0]    irq_status;
    logic [NT-1:0]    irq_ovf;
    logic             host_irq;

    int n_checks = 0;
    int n_err = 0;
    bit finished = 0;

    logic [39:0] exp_q [NT][$];
    logic [NT-1:0] exp_ovf = '0;
    logic [49:0] exp_tx [$];

    always #2 clk = ~clk;

    ring_irq_top dut_i (
        .clk(clk), .rst_n(rst_n), .node_id(node_id),
        .rx_valid(rx_valid), .rx_src(rx_src), .rx_dst(rx_dst),
        .rx_type(rx_type), .rx_data(rx_data),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .tx_valid(tx_valid), .tx_src(tx_src), .tx_dst(tx_dst),
        .tx_type(tx_type), .tx_data(tx_data),
        .pop_req(pop_req), .head_src(head_src), .head_data(head_data),
        .irq_status(irq_status), .irq_ovf(irq_ovf), .host_irq(host_irq)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [NT-1:0] model_status();
        logic [NT-1:0] s;
        for (int t = 0; t < NT; t++) s[t] = (exp_q[t].size() != 0);
        return s;
    endfunction

    // Driver: offer one packet and push the expected entry into the scoreboard.
    task automatic send_pkt(input logic [7:0] src, input logic [7:0] dst,
                            input logic [1:0] typ, input logic [31:0] data,
                            input string req);
        bit accept;
        @(negedge clk);
        rx_valid = 1'b1; rx_src = src; rx_dst = dst; rx_type = typ; rx_data = data;
        accept = (dst == node_id) || (dst == 8'hFF && src != node_id);
        if (accept) begin
            if (exp_q[typ].size() < DEPTH) exp_q[typ].push_back({src, data});
            else exp_ovf[typ] = 1'b1;
        end
        @(negedge clk);
        rx_valid = 1'b0;
        chk(irq_status == model_status(), req, 64'(irq_status), 64'(model_status()));
        chk(irq_ovf == exp_ovf, req, 64'(irq_ovf), 64'(exp_ovf));
    endtask

    task automatic reg_write(input logic [2:0] addr, input logic [31:0] data);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = addr; reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    // Monitor side: pop every entry of one type and compare with the scoreboard.
    task automatic drain(input int t);
        while (exp_q[t].size() != 0) begin
            logic [39:0] e;
            e = exp_q[t].pop_front();
            chk(irq_status[t] == 1'b1, "R5 status while non-empty", 64'(irq_status[t]), 64'd1);
            chk({head_src[t*8 +: 8], head_data[t*32 +: 32]} == e, "R1/R4 head order",
                64'({head_src[t*8 +: 8], head_data[t*32 +: 32]}), 64'(e));
            pop_req[t] = 1'b1;
            @(negedge clk);
            pop_req[t] = 1'b0;
        end
        chk(irq_status[t] == 1'b0, "R5 status clears when drained", 64'(irq_status[t]), 64'd0);
    endtask

    // Emitter monitor: compare each emitted packet with the expected queue.
    always @(negedge clk) begin
        if (rst_n && tx_valid) begin
            if (exp_tx.size() == 0) begin
                chk(1'b0, "R8 unexpected tx", 64'({tx_src, tx_dst, tx_type, tx_data}), 64'd0);
            end else begin
                logic [49:0] e;
                e = exp_tx.pop_front();
                chk({tx_src, tx_dst, tx_type, tx_data} == e, "R8 tx packet",
                    64'({tx_src, tx_dst, tx_type, tx_data}), 64'(e));
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state.
        chk(irq_status == '0, "R9 status", 64'(irq_status), 0);
        chk(irq_ovf == '0, "R9 ovf", 64'(irq_ovf), 0);
        chk(host_irq == 1'b0, "R9 host_irq", 64'(host_irq), 0);
        chk(tx_valid == 1'b0, "R9 tx_valid", 64'(tx_valid), 0);

        // R1: directed packets to several types.
        send_pkt(8'h11, 8'h05, 2'd0, 32'hA000_0001, "R1 directed t0");
        send_pkt(8'h22, 8'h05, 2'd1, 32'hB000_0002, "R1 directed t1");
        send_pkt(8'h33, 8'h05, 2'd0, 32'hA000_0003, "R1 directed t0 second");
        // R3: foreign targets leave all state alone.
        send_pkt(8'h11, 8'h07, 2'd1, 32'hDEAD_0001, "R3 foreign target");
        send_pkt(8'h05, 8'h06, 2'd2, 32'hDEAD_0002, "R3 foreign target from self");
        // R2: broadcasts from others accepted, own broadcast dropped.
        send_pkt(8'h09, 8'hFF, 2'd2, 32'hC000_0004, "R2 foreign broadcast");
        send_pkt(8'h05, 8'hFF, 2'd2, 32'hDEAD_0003, "R2 own broadcast");
        send_pkt(8'h0A, 8'hFF, 2'd1, 32'hC000_0005, "R2 foreign broadcast t1");

        // R7: interrupt masking.
        reg_write(3'd3, 32'h0000_0004);
        chk(host_irq == 1'b0, "R7 global off", 64'(host_irq), 0);
        reg_write(3'd3, 32'h0000_0108);
        chk(host_irq == 1'b0, "R7 local mask on empty type", 64'(host_irq), 0);
        reg_write(3'd3, 32'h0000_0104);
        chk(host_irq == 1'b1, "R7 enabled type pending", 64'(host_irq), 1);

        // R4/R1: drain and compare in order.
        for (int t = 0; t < NT; t++) drain(t);
        chk(host_irq == 1'b0, "R7 drops after drain", 64'(host_irq), 0);

        // R4: pop on empty has no effect.
        @(negedge clk);
        pop_req = 4'b0001;
        @(negedge clk);
        pop_req = '0;
        chk(irq_status == '0, "R4 empty pop", 64'(irq_status), 0);
        send_pkt(8'h44, 8'h05, 2'd0, 32'h1234_5678, "R4 push after empty pop");
        drain(0);

        // R6: fill type 3 to the limit, then overflow.
        for (int i = 0; i < DEPTH; i++)
            send_pkt(8'(i), 8'h05, 2'd3, 32'h3000_0000 + 32'(i), "R6 fill");
        chk(irq_ovf == '0, "R6 no flag at exactly full", 64'(irq_ovf), 0);
        send_pkt(8'hEE, 8'h05, 2'd3, 32'hBAD0_0000, "R6 overflow drop");
        chk(irq_ovf == 4'b1000, "R6 flag set", 64'(irq_ovf), 64'h8);
        drain(3);
        chk(irq_ovf == 4'b1000, "R6 flag sticky", 64'(irq_ovf), 64'h8);
        reg_write(3'd4, 32'h0000_0001);
        chk(irq_ovf == 4'b1000, "R6 clear other bit keeps flag", 64'(irq_ovf), 64'h8);
        reg_write(3'd4, 32'h0000_0008);
        exp_ovf = '0;
        chk(irq_ovf == '0, "R6 flag cleared", 64'(irq_ovf), 0);

        // R8: emit packets.
        reg_write(3'd0, 32'h0000_0023);
        reg_write(3'd1, 32'hCAFE_F00D);
        exp_tx.push_back({8'h05, 8'h23, 2'd2, 32'hCAFE_F00D});
        reg_write(3'd2, 32'h0000_0002);
        reg_write(3'd0, 32'h0000_00FF);
        exp_tx.push_back({8'h05, 8'hFF, 2'd1, 32'hCAFE_F00D});
        reg_write(3'd2, 32'h0000_0001);
        repeat (3) @(negedge clk);
        chk(exp_tx.size() == 0, "R8 all packets emitted", 64'(exp_tx.size()), 0);
        chk(irq_status == '0, "R8 send does not self-enqueue", 64'(irq_status), 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule